// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog

A single free-running 32-bit up-counter is shared by four compare channels. The counter steps forward only on cycles where the tick enable is high, optionally divided further by a parameterised prescaler. Each channel has its own 32-bit match value. When the counter steps onto a channel's match value and that channel's interrupt enable bit is set, the channel's status bit latches and its interrupt line goes high. The line stays high until software clears the status bit by writing 1 to it.

Channel 3 also works as a watchdog. Software can set a one-way watchdog enable. Once it is set, any step of the counter onto the channel-3 match value raises a one-cycle reset-request pulse. This pulse does not depend on that channel's interrupt enable. All registers are reached over a plain register bus: address, write enable, write data, and combinational read data.

Register map (byte offsets): match values at 0x00/0x04/0x08/0x0C for channels 0 to 3, counter at 0x10, status at 0x14, watchdog enable at 0x18, interrupt enable at 0x1C.

Top module: `mtmr_top`

## Requirements
- R1: After reset every mapped register reads 0, all interrupt lines are low and the reset request is low.
- R2: The counter increments by one on each prescaler advance, holds otherwise, and wraps from 0xFFFFFFFF to 0.
- R3: A write to the counter (0x10) loads the written value and counting continues from it. The load itself records no match event.
- R4: When the counter steps onto match value i (offset 4*i) while interrupt enable bit i is set, status bit i and interrupt line i go high at that same clock edge and stay high.
- R5: A match on a channel whose interrupt enable bit is clear sets no status bit and raises no interrupt line.
- R6: Writing the status register (0x14) clears each status bit written as 1 and drops the matching interrupt line. Bits written as 0 keep their value.
- R7: The interrupt enable register (0x1C) stores only bits 11:0. Bits 3:0 enable channels 0 to 3, and bits 31:12 read as 0.
- R8: Writing bit 0 of the watchdog register (0x18) as 1 sets the watchdog enable. Writing 0 does not clear it; only reset does. It reads back in bit 0.
- R9: With the watchdog enable set, the counter stepping onto the channel-3 match value yields exactly one cycle of reset request, whatever interrupt enable bit 3 holds. With the watchdog enable clear, the reset request stays low.
- R10: Reads of unmapped or unaligned offsets return 0, and writes to them change no register.
- R11: With prescaler ratio TICK_DIV, the counter advances once per TICK_DIV tick-enable cycles.
- R12: Match registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count tick enable |
| busAddr | input | 8 | Register byte address |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational on busAddr |
| matchIrq | output | 4 | Per-channel interrupt lines |
| resetReq | output | 1 | Watchdog reset-request pulse |

## Verification
The assertions assume that the bus presents each write as a single-cycle strobe with address and data stable around the capturing edge. They also assume the tick enable is a plain level sampled on each rising edge, and that a counter load and a tick in the same cycle resolve as a load. The stimulus changes every input only on the falling clock edge. It holds the write strobe for exactly one cycle and drives the tick enable for whole-cycle spans, so each sampled edge sees one clean action. The match sweeps step the counter one tick at a time past four staggered match values, under two different enable masks.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int NUM_CH = 4;
  localparam int EN_W   = 12;

  localparam logic [7:0] OFF_MATCH0 = 8'h00;
  localparam logic [7:0] OFF_MATCH1 = 8'h04;
  localparam logic [7:0] OFF_MATCH2 = 8'h08;
  localparam logic [7:0] OFF_MATCH3 = 8'h0C;
  localparam logic [7:0] OFF_COUNT  = 8'h10;
  localparam logic [7:0] OFF_STATUS = 8'h14;
  localparam logic [7:0] OFF_WDOG   = 8'h18;
  localparam logic [7:0] OFF_IRQEN  = 8'h1C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MATCH, SEL_COUNT, SEL_STATUS, SEL_WDOG, SEL_IRQEN
  } rdSel_t;

  typedef struct packed {
    logic [NUM_CH-1:0] wrMatch;
    logic              wrCount;
    logic              wrStatus;
    logic              wrWdog;
    logic              wrIrqEn;
    rdSel_t            rdSel;
    logic [1:0]        matchIdx;
  } strobes_t;
endpackage

// File: rtl/mtmr_prescale.sv
module mtmr_prescale #(
  parameter int TICK_DIV = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  output logic advance
);
  generate
    if (TICK_DIV <= 1) begin : g_direct
      assign advance = tickEn;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] divCnt;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          divCnt <= '0;
        end else if (tickEn) begin
          divCnt <= (divCnt == LAST) ? '0 : divCnt + 1'b1;
        end
      end

      assign advance = tickEn && (divCnt == LAST);

      AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rstN)
        divCnt <= LAST); // R11
      AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rstN)
        advance |=> !advance); // R11
    end
  endgenerate
endmodule

// File: rtl/mtmr_ctrl.sv
module mtmr_ctrl
  import mtmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] busAddr,
  input  logic       busWe,
  output strobes_t   strb
);
  always_comb begin
    strb = '0;
    strb.rdSel = SEL_NONE;
    strb.matchIdx = busAddr[3:2];
    unique case (busAddr)
      OFF_MATCH0, OFF_MATCH1, OFF_MATCH2, OFF_MATCH3: begin
        strb.rdSel = SEL_MATCH;
        strb.wrMatch[busAddr[3:2]] = busWe;
      end
      OFF_COUNT: begin
        strb.rdSel = SEL_COUNT;
        strb.wrCount = busWe;
      end
      OFF_STATUS: begin
        strb.rdSel = SEL_STATUS;
        strb.wrStatus = busWe;
      end
      OFF_WDOG: begin
        strb.rdSel = SEL_WDOG;
        strb.wrWdog = busWe;
      end
      OFF_IRQEN: begin
        strb.rdSel = SEL_IRQEN;
        strb.wrIrqEn = busWe;
      end
      default: strb.rdSel = SEL_NONE;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrMatch, strb.wrCount, strb.wrStatus, strb.wrWdog, strb.wrIrqEn})); // R10
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == SEL_NONE) |-> ({strb.wrMatch, strb.wrCount, strb.wrStatus,
                                   strb.wrWdog, strb.wrIrqEn} == '0)); // R10
endmodule

// File: rtl/mtmr_datapath.sv
module mtmr_datapath
  import mtmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irq,
  output logic              resetReq
);
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] cntStep;
  logic [DATA_W-1:0] matchVal [NUM_CH];
  logic [EN_W-1:0]   status;
  logic [EN_W-1:0]   irqEn;
  logic              wdEn;
  logic [NUM_CH-1:0] hit;
  logic              stepping;

  assign stepping = advance && !strb.wrCount;
  assign cntStep  = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.wrCount) begin
      cnt <= wdata;
    end else if (advance) begin
      cnt <= cntStep;
    end
  end

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      always_ff @(posedge clk) begin
        if (!rstN) begin
          matchVal[i] <= '0;
        end else if (strb.wrMatch[i]) begin
          matchVal[i] <= wdata;
        end
      end

      assign hit[i] = stepping && (cntStep == matchVal[i]);

      AST_STATUS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
        (!$past(status[i]) && status[i]) |-> $past(irqEn[i])); // R5
      AST_STATUS_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
        (!$past(status[i]) && status[i]) |-> (cnt == matchVal[i])); // R4
    end
  endgenerate

  logic [EN_W-1:0] setBits;
  assign setBits = {{(EN_W-NUM_CH){1'b0}}, hit & irqEn[NUM_CH-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
    end else begin
      status <= (strb.wrStatus ? (status & ~wdata[EN_W-1:0]) : status) | setBits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn <= '0;
    end else if (strb.wrIrqEn) begin
      irqEn <= wdata[EN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdEn <= 1'b0;
    end else if (strb.wrWdog && wdata[0]) begin
      wdEn <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resetReq <= 1'b0;
    end else begin
      resetReq <= wdEn && hit[NUM_CH-1];
    end
  end

  assign irq = status[NUM_CH-1:0];

  always_comb begin
    rdata = '0;
    unique case (strb.rdSel)
      SEL_MATCH:  rdata = matchVal[strb.matchIdx];
      SEL_COUNT:  rdata = cnt;
      SEL_STATUS: rdata = DATA_W'(status);
      SEL_WDOG:   rdata = DATA_W'(wdEn);
      SEL_IRQEN:  rdata = DATA_W'(irqEn);
      default:    rdata = '0;
    endcase
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !strb.wrCount) |=> (cnt == $past(cnt) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !strb.wrCount) |=> $stable(cnt)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCount |=> (cnt == $past(wdata))); // R3
  AST_WD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    wdEn |=> wdEn); // R8
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq); // R9
  AST_RST_NEEDS_WD: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> wdEn); // R9
  AST_RST_AT_MATCH3: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (cnt == matchVal[NUM_CH-1])); // R9
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStatus && !stepping) |=> ((status & $past(wdata[EN_W-1:0])) == '0)); // R6
endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
  import mtmr_pkg::*;
#(
  parameter int TICK_DIV = 1,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [7:0]        busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] matchIrq,
  output logic              resetReq
);
  strobes_t strb;
  logic     advance;

  mtmr_prescale #(.TICK_DIV(TICK_DIV)) u_prescale (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .advance(advance)
  );

  mtmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .strb(strb)
  );

  mtmr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .advance(advance), .strb(strb), .wdata(busWdata),
    .rdata(busRdata), .irq(matchIrq), .resetReq(resetReq)
  );
endmodule

// File: tb/mtmr_top_tb.sv
module mtmr_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, divRdata;
  logic [3:0]  matchIrq, divIrq;
  logic        resetReq, divReset;

  int total = 0;
  int bad = 0;
  int rrCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mtmr_top u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .matchIrq(matchIrq), .resetReq(resetReq)
  );

  mtmr_top #(.TICK_DIV(3)) u_div (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(divRdata), .matchIrq(divIrq), .resetReq(divReset)
  );

  always @(negedge clk) if (rstN && resetReq) rrCount++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tickEn = 1'b1;
      repeat (n) @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [31:0] v;
  logic [31:0] mv [4];
  logic [3:0]  expSt;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(8'(a * 4), v);
      check("R1 reg", v, 32'h0);
    end
    check("R1 irq", {28'h0, matchIrq}, 32'h0);
    check("R1 resetReq", {31'h0, resetReq}, 32'h0);

    // R11: divided counter advances once per three ticks; R2 direct one per tick
    ticks(7);
    rd(8'h10, v);
    check("R2 direct count", v, 32'd7);
    check("R11 divided count", divRdata, 32'd2);

    // R12: match registers read back
    for (int i = 0; i < 4; i++) mv[i] = 32'd10 * (i + 1);
    for (int i = 0; i < 4; i++) wr(8'(i * 4), mv[i] ^ 32'hA5000000);
    for (int i = 0; i < 4; i++) begin
      rd(8'(i * 4), v);
      check("R12 match readback", v, mv[i] ^ 32'hA5000000);
    end
    for (int i = 0; i < 4; i++) wr(8'(i * 4), mv[i]);

    // R7: interrupt enable keeps bits 11:0
    wr(8'h1C, 32'hFFFFFFFF);
    rd(8'h1C, v);
    check("R7 irqEn width", v, 32'h00000FFF);

    // R10: unmapped / unaligned offsets
    wr(8'h20, 32'hFFFFFFFF);
    wr(8'h13, 32'h12345678);
    wr(8'h01, 32'h0);
    rd(8'h20, v); check("R10 unmapped read 0x20", v, 32'h0);
    rd(8'h13, v); check("R10 unaligned read 0x13", v, 32'h0);
    rd(8'h10, v); check("R10 count untouched", v, 32'd7);
    rd(8'h00, v); check("R10 match0 untouched", v, mv[0]);
    rd(8'h18, v); check("R10 wdog untouched", v, 32'h0);

    // R3 + R2: load then count
    for (int n = 0; n < 8; n++) begin
      wr(8'h10, 32'd100);
      rd(8'h10, v); check("R3 load", v, 32'd100);
      ticks(n);
      rd(8'h10, v); check("R2 step count", v, 32'd100 + 32'(n));
    end
    wr(8'h10, 32'hFFFFFFFE);
    ticks(3);
    rd(8'h10, v); check("R2 wrap", v, 32'h1);

    // R3: load onto a match value records nothing
    wr(8'h14, 32'hFFF);
    wr(8'h10, mv[1]);
    rd(8'h14, v); check("R3 load no event", v, 32'h0);

    // Sweep with enables 0101: R4, R5
    wr(8'h1C, 32'h5);
    wr(8'h10, 32'h0);
    wr(8'h14, 32'hFFF);
    for (int s = 1; s <= 45; s++) begin
      ticks(1);
      expSt = '0;
      for (int i = 0; i < 4; i++)
        if (((32'h5 >> i) & 1) != 0 && 32'(s) >= mv[i]) expSt[i] = 1'b1;
      rd(8'h14, v);
      check("R4/R5 status sweep A", v, {28'h0, expSt});
      check("R4 irq sweep A", {28'h0, matchIrq}, {28'h0, expSt});
    end

    // R6: write-one-to-clear
    wr(8'h14, 32'h1);
    rd(8'h14, v); check("R6 clear bit0", v, 32'h4);
    wr(8'h14, 32'h0);
    rd(8'h14, v); check("R6 zero write keeps", v, 32'h4);
    check("R6 irq after clear", {28'h0, matchIrq}, 32'h4);
    wr(8'h14, 32'hFFF);

    // Sweep with all enables
    wr(8'h1C, 32'hF);
    wr(8'h10, 32'h0);
    for (int s = 1; s <= 45; s++) begin
      ticks(1);
      expSt = '0;
      for (int i = 0; i < 4; i++) if (32'(s) >= mv[i]) expSt[i] = 1'b1;
      rd(8'h14, v);
      check("R4 status sweep B", v, {28'h0, expSt});
      check("R4 irq sweep B", {28'h0, matchIrq}, {28'h0, expSt});
    end
    wr(8'h14, 32'h5);
    rd(8'h14, v); check("R6 partial clear", v, 32'hA);
    check("R6 irq partial", {28'h0, matchIrq}, 32'hA);
    wr(8'h14, 32'hA);
    rd(8'h14, v); check("R6 full clear", v, 32'h0);
    check("R9 no pulse while watchdog off", rrCount, 0);

    // R8: sticky watchdog enable
    wr(8'h18, 32'h1);
    rd(8'h18, v); check("R8 set", v, 32'h1);
    wr(8'h18, 32'h0);
    rd(8'h18, v); check("R8 sticky", v, 32'h1);

    // R9: reset request regardless of irq enable bit 3
    wr(8'h1C, 32'h0);
    wr(8'h10, 32'd35);
    ticks(4);
    check("R9 no early pulse", rrCount, 0);
    ticks(1);
    @(negedge clk);
    check("R9 single pulse", rrCount, 1);
    rd(8'h14, v); check("R9/R5 no status with enable clear", v, 32'h0);
    ticks(3);
    check("R9 no repeat", rrCount, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule